// File: doc/BRIEF.md
# Message Buffer Interrupt Aggregator

This block gathers completion events from a bank of message buffers in a bus controller, together with the controller's error-state events. From them it builds the controller's interrupt request lines. Each buffer owns one sticky flag. The flag sets when that buffer finishes a good transmission or a good reception. The two directions are not told apart. The host clears a flag by writing 1 to its bit position. A host-written mask decides which flags may raise an interrupt. The low buffers each drive a line of their own. The upper buffers are folded into two OR-ed group lines, so the host must read the flag register to learn which buffer fired.

A separate four-bit status register records error-state events: a protocol error, bus-off, a transmit warning and a receive warning. Its bits clear the same way, by writing 1. A two-bit control register gates two lines from this register. One is the error line. The other is a combined line for bus-off and the two warnings.

Every request line is registered and level-sensitive. A line stays high for as long as any masked source behind it is still set. The block has no streaming data path, so all of its pins are plain control and status signals with no valid/ready handshake.

Top module: `mbi_aggregator`

## Requirements
- R1: While `rst_n` is low, and afterwards until another write or event, `flag_q`, `mask_q`, `ctrl_q`, `stat_q` and every interrupt output are zero.
- R2: A high bit `buf_done[i]` at a clock edge sets `flag_q[i]` at that edge. The same input serves both transmit and receive completion.
- R3: When `flag_clr_we` is high at an edge, each `flag_clr_data` bit at 1 clears the matching flag. Bits at 0 leave their flags unchanged. A flag never clears any other way.
- R4: If `buf_done[i]` and a clear of bit i arrive at the same edge, the flag ends up set.
- R5: `irq_buf[i]` for i below 16 equals `flag_q[i] & mask_q[i]` as held one cycle earlier. `mask_q` loads `mask_data` whenever `mask_we` is high.
- R6: `irq_grp_mid` is the OR of `flag_q & mask_q` over buffers 16 to 31, as held one cycle earlier.
- R7: `irq_grp_high` is the OR of `flag_q & mask_q` over buffers 32 to 63, as held one cycle earlier.
- R8: The status bits are bit 0 error, bit 1 bus-off, bit 2 transmit warning and bit 3 receive warning. They are set by `err_hit`, `bus_off_hit`, `tx_warn_hit` and `rx_warn_hit`. They clear by writing 1 through `stat_clr_we`/`stat_clr_data`. A set wins over a clear at the same edge.
- R9: `ctrl_q` loads `ctrl_data` when `ctrl_we` is high. `irq_err` equals `stat_q[0] & ctrl_q[0]` as held one cycle earlier.
- R10: `irq_boff_warn` equals the OR of `stat_q[3:1]`, ANDed with `ctrl_q[1]`, as held one cycle earlier.
- R11: With no further events or writes, every asserted interrupt line stays asserted from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| buf_done | input | 64 | One-cycle completion pulse per buffer |
| err_hit | input | 1 | Error event pulse |
| bus_off_hit | input | 1 | Bus-off event pulse |
| tx_warn_hit | input | 1 | Transmit warning event pulse |
| rx_warn_hit | input | 1 | Receive warning event pulse |
| flag_clr_we | input | 1 | Flag write-1-to-clear strobe |
| flag_clr_data | input | 64 | Flags to clear |
| mask_we | input | 1 | Mask write strobe |
| mask_data | input | 64 | New mask value |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_data | input | 2 | Bit 0 error enable, bit 1 bus-off/warning enable |
| stat_clr_we | input | 1 | Status write-1-to-clear strobe |
| stat_clr_data | input | 4 | Status bits to clear |
| flag_q | output | 64 | Flag register |
| mask_q | output | 64 | Mask register |
| ctrl_q | output | 2 | Control register |
| stat_q | output | 4 | Status register |
| irq_buf | output | 16 | Per-buffer lines for buffers 0 to 15 |
| irq_grp_mid | output | 1 | Group line for buffers 16 to 31 |
| irq_grp_high | output | 1 | Group line for buffers 32 to 63 |
| irq_err | output | 1 | Error line |
| irq_boff_warn | output | 1 | Combined bus-off / warning line |

## Verification
The bench drives a set and a clear into the same flag on the same edge, on both the flag register and the status register. A design that gives the clear priority would lose that completion, and the line would drop. It writes clears carrying zero bits to show that unselected flags survive. A design that loads the clear data directly would wipe them. It moves set flags across the boundaries at buffers 15/16 and 31/32. A group reduction with misplaced bounds would raise the wrong line or miss one. It also leaves a source enabled but its gate closed, for example a status bit set while its control enable is clear. A gate wired the wrong way would assert the line anyway.

// File: rtl/mbi_pkg.sv
package mbi_pkg;
  // status register bit positions (decoded by the line map)
  localparam int unsigned STAT_ERR  = 0;
  localparam int unsigned STAT_BOFF = 1;
  localparam int unsigned STAT_TXW  = 2;
  localparam int unsigned STAT_RXW  = 3;
  localparam int unsigned STAT_W    = 4;

  // control register bit positions
  localparam int unsigned CTRL_ERR_EN = 0;
  localparam int unsigned CTRL_BW_EN  = 1;
  localparam int unsigned CTRL_W      = 2;

  typedef struct packed {
    logic rx_warn;
    logic tx_warn;
    logic bus_off;
    logic err;
  } stat_t;

  typedef struct packed {
    logic bw_en;
    logic err_en;
  } ctrl_t;
endpackage

// File: rtl/mbi_w1c_bank.sv
// Sticky flag bank: per-bit set pulse, write-1-to-clear, set has priority.
module mbi_w1c_bank #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_we,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic bit_q;
    logic clr_hit;
    assign clr_hit = clr_we & clr_i[b];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        bit_q <= 1'b0;
      else if (set_i[b]) bit_q <= 1'b1;
      else if (clr_hit)  bit_q <= 1'b0;
    end
    assign q_o[b] = bit_q;
  end
endmodule

// File: rtl/mbi_wr_reg.sv
// Host-written register with load strobe.
module mbi_wr_reg #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_o <= '0;
    else if (we) q_o <= d_i;
  end
endmodule

// File: rtl/mbi_irq_map.sv
// Registered interrupt line map: solo lines, two OR groups, status lines.
module mbi_irq_map
  import mbi_pkg::*;
#(
  parameter int unsigned NUM_BUF   = 64,
  parameter int unsigned NUM_SOLO  = 16,
  parameter int unsigned GRP_SPLIT = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_BUF-1:0]  flag_i,
  input  logic [NUM_BUF-1:0]  mask_i,
  input  stat_t               stat_i,
  input  ctrl_t               ctrl_i,
  output logic [NUM_SOLO-1:0] irq_solo_o,
  output logic                irq_mid_o,
  output logic                irq_high_o,
  output logic                irq_err_o,
  output logic                irq_bw_o
);
  localparam int unsigned MID_W  = GRP_SPLIT - NUM_SOLO;
  localparam int unsigned HIGH_W = NUM_BUF - GRP_SPLIT;

  logic [NUM_BUF-1:0] live;
  logic [MID_W-1:0]   live_mid;
  logic [HIGH_W-1:0]  live_high;
  logic               mid_any, high_any, err_any, bw_any;

  assign live      = flag_i & mask_i;
  assign live_mid  = live[GRP_SPLIT-1:NUM_SOLO];
  assign live_high = live[NUM_BUF-1:GRP_SPLIT];
  assign mid_any   = |live_mid;
  assign high_any  = |live_high;
  assign err_any   = stat_i.err & ctrl_i.err_en;
  assign bw_any    = (stat_i.bus_off | stat_i.tx_warn | stat_i.rx_warn) & ctrl_i.bw_en;

  for (genvar s = 0; s < NUM_SOLO; s++) begin : g_solo
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_solo_o[s] <= 1'b0;
      else        irq_solo_o[s] <= live[s];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_mid_o  <= 1'b0;
      irq_high_o <= 1'b0;
      irq_err_o  <= 1'b0;
      irq_bw_o   <= 1'b0;
    end else begin
      irq_mid_o  <= mid_any;
      irq_high_o <= high_any;
      irq_err_o  <= err_any;
      irq_bw_o   <= bw_any;
    end
  end
endmodule

// File: rtl/mbi_aggregator.sv
module mbi_aggregator
  import mbi_pkg::*;
#(
  parameter int unsigned NUM_BUF   = 64,
  parameter int unsigned NUM_SOLO  = 16,
  parameter int unsigned GRP_SPLIT = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_BUF-1:0]  buf_done,
  input  logic                err_hit,
  input  logic                bus_off_hit,
  input  logic                tx_warn_hit,
  input  logic                rx_warn_hit,
  input  logic                flag_clr_we,
  input  logic [NUM_BUF-1:0]  flag_clr_data,
  input  logic                mask_we,
  input  logic [NUM_BUF-1:0]  mask_data,
  input  logic                ctrl_we,
  input  logic [1:0]          ctrl_data,
  input  logic                stat_clr_we,
  input  logic [3:0]          stat_clr_data,
  output logic [NUM_BUF-1:0]  flag_q,
  output logic [NUM_BUF-1:0]  mask_q,
  output logic [1:0]          ctrl_q,
  output logic [3:0]          stat_q,
  output logic [NUM_SOLO-1:0] irq_buf,
  output logic                irq_grp_mid,
  output logic                irq_grp_high,
  output logic                irq_err,
  output logic                irq_boff_warn
);
  stat_t stat_set;
  stat_t stat_cur;
  ctrl_t ctrl_cur;

  always_comb begin
    stat_set         = '0;
    stat_set.err     = err_hit;
    stat_set.bus_off = bus_off_hit;
    stat_set.tx_warn = tx_warn_hit;
    stat_set.rx_warn = rx_warn_hit;
  end

  mbi_w1c_bank #(.W(NUM_BUF)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(buf_done),
    .clr_we(flag_clr_we), .clr_i(flag_clr_data), .q_o(flag_q)
  );

  mbi_wr_reg #(.W(NUM_BUF)) u_mask (
    .clk(clk), .rst_n(rst_n), .we(mask_we), .d_i(mask_data), .q_o(mask_q)
  );

  mbi_w1c_bank #(.W(STAT_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .set_i(stat_set),
    .clr_we(stat_clr_we), .clr_i(stat_clr_data), .q_o(stat_q)
  );

  mbi_wr_reg #(.W(CTRL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(ctrl_we), .d_i(ctrl_data), .q_o(ctrl_q)
  );

  assign stat_cur = stat_t'(stat_q);
  assign ctrl_cur = ctrl_t'(ctrl_q);

  mbi_irq_map #(
    .NUM_BUF(NUM_BUF), .NUM_SOLO(NUM_SOLO), .GRP_SPLIT(GRP_SPLIT)
  ) u_map (
    .clk(clk), .rst_n(rst_n),
    .flag_i(flag_q), .mask_i(mask_q), .stat_i(stat_cur), .ctrl_i(ctrl_cur),
    .irq_solo_o(irq_buf), .irq_mid_o(irq_grp_mid), .irq_high_o(irq_grp_high),
    .irq_err_o(irq_err), .irq_bw_o(irq_boff_warn)
  );
endmodule

// File: rtl/mbi_aggregator_chk.sv
module mbi_aggregator_chk #(
  parameter int unsigned NUM_BUF   = 64,
  parameter int unsigned NUM_SOLO  = 16,
  parameter int unsigned GRP_SPLIT = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_BUF-1:0]  buf_done,
  input logic                flag_clr_we,
  input logic [NUM_BUF-1:0]  flag_clr_data,
  input logic [NUM_BUF-1:0]  flag_q,
  input logic [NUM_BUF-1:0]  mask_q,
  input logic [1:0]          ctrl_q,
  input logic [3:0]          stat_q,
  input logic [NUM_SOLO-1:0] irq_buf,
  input logic                irq_grp_mid,
  input logic                irq_grp_high,
  input logic                irq_err,
  input logic                irq_boff_warn
);
  AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (|buf_done) |=> ((flag_q & $past(buf_done)) == $past(buf_done)));  // R4
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(buf_done)) == '0));  // R2
  AST_CLEAR_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(flag_q) & ~flag_q & ~($past(flag_clr_we) ? $past(flag_clr_data) : '0)) == '0));  // R3
  AST_SOLO_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_buf == $past(flag_q[NUM_SOLO-1:0] & mask_q[NUM_SOLO-1:0])));  // R5
  AST_GROUP_MID: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_grp_mid == $past(|(flag_q[GRP_SPLIT-1:NUM_SOLO] & mask_q[GRP_SPLIT-1:NUM_SOLO]))));  // R6
  AST_GROUP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_grp_high == $past(|(flag_q[NUM_BUF-1:GRP_SPLIT] & mask_q[NUM_BUF-1:GRP_SPLIT]))));  // R7
  AST_ERR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_err == $past(stat_q[0] & ctrl_q[0])));  // R9
  AST_BW_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_boff_warn == $past((|stat_q[3:1]) & ctrl_q[1])));  // R10
endmodule

bind mbi_aggregator mbi_aggregator_chk #(
  .NUM_BUF(NUM_BUF), .NUM_SOLO(NUM_SOLO), .GRP_SPLIT(GRP_SPLIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .buf_done(buf_done),
  .flag_clr_we(flag_clr_we), .flag_clr_data(flag_clr_data),
  .flag_q(flag_q), .mask_q(mask_q), .ctrl_q(ctrl_q), .stat_q(stat_q),
  .irq_buf(irq_buf), .irq_grp_mid(irq_grp_mid), .irq_grp_high(irq_grp_high),
  .irq_err(irq_err), .irq_boff_warn(irq_boff_warn)
);

// File: tb/mbi_aggregator_test.sv
`timescale 1ns/1ps
module mbi_aggregator_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] buf_done = '0;
  logic        err_hit = 0, bus_off_hit = 0, tx_warn_hit = 0, rx_warn_hit = 0;
  logic        flag_clr_we = 0;
  logic [63:0] flag_clr_data = '0;
  logic        mask_we = 0;
  logic [63:0] mask_data = '0;
  logic        ctrl_we = 0;
  logic [1:0]  ctrl_data = '0;
  logic        stat_clr_we = 0;
  logic [3:0]  stat_clr_data = '0;
  logic [63:0] flag_q, mask_q;
  logic [1:0]  ctrl_q;
  logic [3:0]  stat_q;
  logic [15:0] irq_buf;
  logic        irq_grp_mid, irq_grp_high, irq_err, irq_boff_warn;

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] fm = '0;
  logic [63:0] mm = '0;

  always #2.5 clk = ~clk;

  mbi_aggregator uut (
    .clk(clk), .rst_n(rst_n), .buf_done(buf_done),
    .err_hit(err_hit), .bus_off_hit(bus_off_hit), .tx_warn_hit(tx_warn_hit), .rx_warn_hit(rx_warn_hit),
    .flag_clr_we(flag_clr_we), .flag_clr_data(flag_clr_data),
    .mask_we(mask_we), .mask_data(mask_data), .ctrl_we(ctrl_we), .ctrl_data(ctrl_data),
    .stat_clr_we(stat_clr_we), .stat_clr_data(stat_clr_data),
    .flag_q(flag_q), .mask_q(mask_q), .ctrl_q(ctrl_q), .stat_q(stat_q),
    .irq_buf(irq_buf), .irq_grp_mid(irq_grp_mid), .irq_grp_high(irq_grp_high),
    .irq_err(irq_err), .irq_boff_warn(irq_boff_warn)
  );

  localparam int NV = 8;
  localparam logic [63:0] V_SET [NV] = '{
    64'h0000_0000_0000_0001, 64'h0000_0000_0001_0000, 64'h0000_0100_0000_0000, 64'h0,
    64'h0000_0000_0000_0020, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0};
  localparam logic [63:0] V_CLR [NV] = '{
    64'h0, 64'h0, 64'h0000_0000_0000_0001, 64'h0,
    64'h0000_0000_0001_0020, 64'h0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF};
  localparam logic [63:0] V_MSK [NV] = '{
    64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0,
    64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0100_0000_0000, 64'hFFFF_0000_8000_0020, 64'hFFFF_FFFF_FFFF_FFFF};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one cycle of stimulus, then wait until the line stage has caught up
  task automatic apply(input logic [63:0] set, input logic cwe, input logic [63:0] clr,
                       input logic mwe, input logic [63:0] msk,
                       input logic kwe, input logic [1:0] kd,
                       input logic swe, input logic [3:0] sclr, input logic [3:0] evt);
    @(negedge clk);
    buf_done = set; flag_clr_we = cwe; flag_clr_data = clr;
    mask_we = mwe; mask_data = msk; ctrl_we = kwe; ctrl_data = kd;
    stat_clr_we = swe; stat_clr_data = sclr;
    {rx_warn_hit, tx_warn_hit, bus_off_hit, err_hit} = evt;
    @(negedge clk);
    buf_done = '0; flag_clr_we = 0; flag_clr_data = '0; mask_we = 0; mask_data = '0;
    ctrl_we = 0; ctrl_data = '0; stat_clr_we = 0; stat_clr_data = '0;
    {rx_warn_hit, tx_warn_hit, bus_off_hit, err_hit} = '0;
    @(negedge clk);
  endtask

  task automatic chk_lines(input string tag);
    logic [63:0] lv;
    lv = fm & mm;
    chk({tag, " R2 R3 R4 flags"}, flag_q, fm);
    chk({tag, " R5 mask"}, mask_q, mm);
    chk({tag, " R5 solo lines"}, {48'h0, irq_buf}, {48'h0, lv[15:0]});
    chk({tag, " R6 group mid"}, {63'h0, irq_grp_mid}, {63'h0, |lv[31:16]});
    chk({tag, " R7 group high"}, {63'h0, irq_grp_high}, {63'h0, |lv[63:32]});
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #12;
    // R1 reset state
    chk("R1 flags", flag_q, '0);
    chk("R1 mask", mask_q, '0);
    chk("R1 ctrl/stat", {58'h0, ctrl_q, stat_q}, '0);
    chk("R1 lines", {44'h0, irq_buf, irq_grp_mid, irq_grp_high, irq_err, irq_boff_warn}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 after release", {irq_buf, irq_grp_mid, irq_grp_high, stat_q}, '0);

    // table walk over flags and mask
    for (int v = 0; v < NV; v++) begin
      apply(V_SET[v], 1'b1, V_CLR[v], 1'b1, V_MSK[v], 1'b0, 2'b0, 1'b0, 4'h0, 4'h0);
      fm = (fm & ~V_CLR[v]) | V_SET[v];
      mm = V_MSK[v];
      chk_lines($sformatf("vec%0d", v));
    end

    // R11 level hold: raise lines then idle
    apply(64'h8000_0001_0001_0004, 1'b0, '0, 1'b0, '0, 1'b0, 2'b0, 1'b0, 4'h0, 4'h0);
    fm = fm | 64'h8000_0001_0001_0004;
    repeat (6) @(negedge clk);
    chk_lines("R11 hold");

    // status / control path
    apply('0, 1'b0, '0, 1'b0, '0, 1'b0, 2'b0, 1'b0, 4'h0, 4'h1);
    chk("R8 err status set", {60'h0, stat_q}, 64'h1);
    chk("R9 err gated off", {63'h0, irq_err}, 64'h0);
    apply('0, 1'b0, '0, 1'b0, '0, 1'b1, 2'b01, 1'b0, 4'h0, 4'h0);
    chk("R9 ctrl readback", {62'h0, ctrl_q}, 64'h1);
    chk("R9 err enabled", {63'h0, irq_err}, 64'h1);
    apply('0, 1'b0, '0, 1'b0, '0, 1'b0, 2'b0, 1'b0, 4'h0, 4'h4);
    chk("R8 txwarn status", {60'h0, stat_q}, 64'h5);
    chk("R10 bw gated off", {63'h0, irq_boff_warn}, 64'h0);
    apply('0, 1'b0, '0, 1'b0, '0, 1'b1, 2'b11, 1'b0, 4'h0, 4'h0);
    chk("R10 bw enabled", {63'h0, irq_boff_warn}, 64'h1);
    apply('0, 1'b0, '0, 1'b0, '0, 1'b0, 2'b0, 1'b1, 4'h1, 4'h1);
    chk("R8 set beats clear", {60'h0, stat_q}, 64'h5);
    chk("R9 err held", {63'h0, irq_err}, 64'h1);
    apply('0, 1'b0, '0, 1'b0, '0, 1'b0, 2'b0, 1'b1, 4'h4, 4'h0);
    chk("R8 partial clear", {60'h0, stat_q}, 64'h1);
    chk("R10 bw dropped", {63'h0, irq_boff_warn}, 64'h0);
    apply('0, 1'b0, '0, 1'b0, '0, 1'b0, 2'b0, 1'b0, 4'h0, 4'h8);
    chk("R10 rxwarn line", {63'h0, irq_boff_warn}, 64'h1);
    apply('0, 1'b0, '0, 1'b0, '0, 1'b0, 2'b0, 1'b1, 4'hF, 4'h0);
    chk("R8 all cleared", {60'h0, stat_q}, 64'h0);
    chk("R9 R10 lines low", {62'h0, irq_err, irq_boff_warn}, 64'h0);
    chk_lines("R3 flags untouched by status");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule